// File: doc/BRIEF.md
# Clocked Serial Transmitter with Optional Double Buffering

This block is the transmit half of a synchronous serial port. It acts as the clock master. A host loads bytes through a one-cycle write strobe. Each byte is sent on a data line, least significant bit first, together with a shift clock that the block generates from the system clock using a programmable divider. The shift clock runs only while there is data to send. When the last byte has gone out and nothing is waiting, the clock stops high.

A configuration input selects one of two modes.

- **Single-buffered mode:** a write starts one byte, and an interrupt pulse marks the end of that byte.
- **Double-buffered mode:** a holding register sits in front of the shifter. A byte moves from the holding register into the shifter either at once, if the shifter is idle, or at the exact cycle the previous byte finishes, so back-to-back bytes run without a gap. Each such move sets the empty flag and pulses the interrupt, which asks the host for the next byte.

A sticky overrun flag records every write that was lost or overwrote unsent data.

Top module: `sst_tx`

## Requirements
- R1: After reset the outputs are as follows: `buf_empty`=1, `sclk`=1, `txd`=1, `busy`=0, `overrun`=0, `tx_irq`=0.
- R2: Bits leave least significant bit first. `txd` changes only when `sclk` falls (or as the line returns to idle), and it is stable while `sclk` is high. `sclk` idles high.
- R3: Each half period of `sclk` lasts `div_val` system clock cycles. A `div_val` of 0 acts as 1.
- R4: In single-buffered mode (`dbuf_en`=0), `tx_irq` is high in cycle 1+16·D after the write edge, where D is the effective divisor. This marks that the byte is complete. No pulse is produced when the byte starts.
- R5: In single-buffered mode, a write while a byte is in progress or pending is dropped and sets `overrun`.
- R6: In double-buffered mode (`dbuf_en`=1), a write to an idle shifter moves the byte into the shifter on the next edge. In the cycle after that edge, `buf_empty` is 1 and `tx_irq` pulses.
- R7: In double-buffered mode, a byte held in the buffer moves into the shifter at the edge where the current byte completes. The move raises an interrupt pulse, and `busy` stays high with no gap in `sclk`.
- R8: When a byte completes and the buffer is empty, no interrupt is raised, `busy` falls, and `sclk` and `txd` rest high.
- R9: In double-buffered mode, a write while the buffer already holds unsent data overwrites that data and sets `overrun`. A write in the same cycle as a move is accepted without overrun. `overrun` stays set until reset.
- R10: An accepted host write clears `buf_empty`.
- R11: Clearing `dbuf_en` during a byte that started in double-buffered mode does not add an end-of-byte interrupt to that byte. The new mode applies from the next byte.
- R12: `tx_irq` is a pulse one system clock cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| dbuf_en | input | 1 | 1 selects double-buffered mode |
| div_val | input | DIV_W | Half period of `sclk` in system cycles (0 acts as 1) |
| wr_stb | input | 1 | One-cycle host write strobe |
| wr_data | input | DATA_W | Byte to transmit |
| sclk | output | 1 | Shift clock, idles high |
| txd | output | 1 | Serial data, idles high |
| tx_irq | output | 1 | Transmit interrupt pulse |
| buf_empty | output | 1 | Transmit buffer empty flag |
| overrun | output | 1 | Sticky lost-write flag |
| busy | output | 1 | Shifter active |

## Verification
Two events can fall on the same system clock edge in double-buffered mode:

- a host write to the buffer;
- the completion-time move of the buffered byte into the shifter.

The bench provokes this by counting cycles from the first write and placing a third write on the edge where the first byte finishes. The run is judged correct when three conditions hold:

- all three bytes arrive in order;
- exactly three interrupt pulses are seen;
- `overrun` stays clear.

The opposite case, where a write lands with no move in the same cycle, is checked next to it and must set `overrun` and lose the overwritten byte.

// File: rtl/sst_pkg.sv
package sst_pkg;
  typedef enum logic {
    XFER_SINGLE = 1'b0,
    XFER_DOUBLE = 1'b1
  } xfer_mode_e;
endpackage

// File: rtl/sst_clkdiv.sv
module sst_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] div_eff;

  // A zero divisor is treated as one system cycle per half period.
  assign div_eff = (div_val == '0) ? DIV_W'(1) : div_val;
  assign tick    = run && (cnt_q >= (div_eff - DIV_W'(1)));

  always_ff @(posedge clk) begin
    if (rst || restart || !run) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/sst_shifter.sv
module sst_shifter
  import sst_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  xfer_mode_e        load_mode,
  input  logic              tick,
  output logic              sclk,
  output logic              txd,
  output logic              busy,
  output logic              done,
  output xfer_mode_e        cur_mode
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic [DATA_W-1:0] sr_q;
  logic [CNT_W-1:0]  bit_q;
  logic              sclk_q;
  logic              txd_q;
  logic              busy_q;
  xfer_mode_e        mode_q;
  logic              last_bit;

  assign last_bit = (bit_q == CNT_W'(DATA_W - 1));
  // The byte ends one half period after the rising edge of its last bit.
  assign done     = busy_q && tick && sclk_q && last_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q   <= '0;
      bit_q  <= '0;
      sclk_q <= 1'b1;
      txd_q  <= 1'b1;
      busy_q <= 1'b0;
      mode_q <= XFER_SINGLE;
    end else if (load) begin
      // Loading drives sclk low: this is the falling edge that presents bit 0.
      sr_q   <= load_data;
      bit_q  <= '0;
      sclk_q <= 1'b0;
      txd_q  <= load_data[0];
      busy_q <= 1'b1;
      mode_q <= load_mode;
    end else if (done) begin
      sclk_q <= 1'b1;
      txd_q  <= 1'b1;
      busy_q <= 1'b0;
    end else if (busy_q && tick) begin
      if (!sclk_q) begin
        sclk_q <= 1'b1;
      end else begin
        sclk_q <= 1'b0;
        sr_q   <= sr_q >> 1;
        txd_q  <= sr_q[1];
        bit_q  <= bit_q + CNT_W'(1);
      end
    end
  end

  assign sclk     = sclk_q;
  assign txd      = txd_q;
  assign busy     = busy_q;
  assign cur_mode = mode_q;
endmodule

// File: rtl/sst_bufctl.sv
module sst_bufctl
  import sst_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              dbuf_en,
  input  logic              busy,
  input  logic              done,
  input  xfer_mode_e        cur_mode,
  output logic              load,
  output logic [DATA_W-1:0] load_data,
  output xfer_mode_e        load_mode,
  output logic              irq,
  output logic              buf_empty,
  output logic              overrun
);
  logic [DATA_W-1:0] buf_q;
  logic              full_q;
  logic              irq_q;
  logic              ovr_q;
  logic              move;
  logic              accept;
  logic              lost;

  assign move = full_q && (!busy || done);

  // Single-buffered mode only takes a write when nothing is pending or shifting.
  assign accept = wr_stb && (dbuf_en || (!busy && !full_q));
  assign lost   = wr_stb && ((dbuf_en && full_q && !move) ||
                             (!dbuf_en && (busy || full_q)));

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q  <= '0;
      full_q <= 1'b0;
      irq_q  <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (accept) begin
        buf_q <= wr_data;
      end
      if (accept) begin
        full_q <= 1'b1;
      end else if (move) begin
        full_q <= 1'b0;
      end
      irq_q <= (move && dbuf_en) || (done && (cur_mode == XFER_SINGLE));
      if (lost) begin
        ovr_q <= 1'b1;
      end
    end
  end

  assign load      = move;
  assign load_data = buf_q;
  assign load_mode = dbuf_en ? XFER_DOUBLE : XFER_SINGLE;
  assign irq       = irq_q;
  // A single-buffered byte keeps the buffer occupied until it finishes.
  assign buf_empty = !full_q && !(busy && (cur_mode == XFER_SINGLE));
  assign overrun   = ovr_q;
endmodule

// File: rtl/sst_tx.sv
module sst_tx
  import sst_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dbuf_en,
  input  logic [DIV_W-1:0]  div_val,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  output logic              sclk,
  output logic              txd,
  output logic              tx_irq,
  output logic              buf_empty,
  output logic              overrun,
  output logic              busy
);
  logic              load;
  logic [DATA_W-1:0] load_data;
  xfer_mode_e        load_mode;
  xfer_mode_e        cur_mode;
  logic              tick;
  logic              done;

  sst_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk     (clk),
    .rst     (rst),
    .run     (busy),
    .restart (load),
    .div_val (div_val),
    .tick    (tick)
  );

  sst_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .load_data (load_data),
    .load_mode (load_mode),
    .tick      (tick),
    .sclk      (sclk),
    .txd       (txd),
    .busy      (busy),
    .done      (done),
    .cur_mode  (cur_mode)
  );

  sst_bufctl #(.DATA_W(DATA_W)) u_buf (
    .clk       (clk),
    .rst       (rst),
    .wr_stb    (wr_stb),
    .wr_data   (wr_data),
    .dbuf_en   (dbuf_en),
    .busy      (busy),
    .done      (done),
    .cur_mode  (cur_mode),
    .load      (load),
    .load_data (load_data),
    .load_mode (load_mode),
    .irq       (tx_irq),
    .buf_empty (buf_empty),
    .overrun   (overrun)
  );
endmodule

// File: rtl/sst_tx_chk.sv
module sst_tx_chk (
  input logic clk,
  input logic rst,
  input logic dbuf_en,
  input logic wr_stb,
  input logic sclk,
  input logic txd,
  input logic tx_irq,
  input logic buf_empty,
  input logic overrun,
  input logic busy
);
  p_irq_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    tx_irq |=> !tx_irq);

  p_idle_lines_r8: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (sclk && txd));

  p_write_clears_empty_r10: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && dbuf_en) |=> !buf_empty);

  p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);

  p_txd_stable_high_r2: assert property (@(posedge clk) disable iff (rst)
    (busy && sclk && $past(sclk)) |-> $stable(txd));
endmodule

bind sst_tx sst_tx_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .dbuf_en   (dbuf_en),
  .wr_stb    (wr_stb),
  .sclk      (sclk),
  .txd       (txd),
  .tx_irq    (tx_irq),
  .buf_empty (buf_empty),
  .overrun   (overrun),
  .busy      (busy)
);

// File: tb/sst_tx_tb.sv
module sst_tx_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dbuf_en = 1'b0;
  logic [7:0] div_val = 8'd1;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       sclk, txd, tx_irq, buf_empty, overrun, busy;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sst_tx u_dut (
    .clk(clk), .rst(rst), .dbuf_en(dbuf_en), .div_val(div_val),
    .wr_stb(wr_stb), .wr_data(wr_data), .sclk(sclk), .txd(txd),
    .tx_irq(tx_irq), .buf_empty(buf_empty), .overrun(overrun), .busy(busy)
  );

  // Line monitor: captures bits on sclk rising edges, counts interrupt pulses.
  logic [7:0] rx_bytes [0:63];
  int         rx_count = 0;
  int         irq_count = 0;
  logic [7:0] rx_sr = 8'h00;
  int         rx_bits = 0;
  logic       prev_sclk = 1'b1;
  logic       prev_txd = 1'b1;
  logic       prev_irq = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst) begin
      rx_bits = 0;
    end else begin
      if (sclk && !prev_sclk) begin
        rx_sr = {txd, rx_sr[7:1]};
        rx_bits++;
        if (rx_bits == 8) begin
          rx_bytes[rx_count % 64] = rx_sr;
          rx_count++;
          rx_bits = 0;
        end
      end
      if (busy && sclk && prev_sclk && (txd != prev_txd))
        chk(1'b0, "R2 txd moved while sclk high", int'(txd), int'(prev_txd));
      if (tx_irq && prev_irq)
        chk(1'b0, "R12 irq wider than one cycle", 2, 1);
      if (tx_irq) irq_count++;
    end
    prev_sclk = sclk;
    prev_txd  = txd;
    prev_irq  = tx_irq;
  end

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; wr_stb = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
  endtask

  // Drive a write sampled at the next edge; returns at the negedge after it (k=0).
  task automatic write_byte(input logic [7:0] d);
    wr_stb = 1'b1; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic wait_irq(output int k);
    k = 0;
    while (!tx_irq && k < 5000) begin
      @(negedge clk); k++;
    end
  endtask

  task automatic wait_rx(input int target);
    int t = 0;
    while (rx_count < target && t < 20000) begin
      @(negedge clk); t++;
    end
    while (busy && t < 20000) begin
      @(negedge clk); t++;
    end
    repeat (3) @(negedge clk);
  endtask

  // {dbuf_en, div[3:0], data}
  localparam logic [12:0] VEC [6] = '{
    {1'b0, 4'd1, 8'hA5}, {1'b1, 4'd2, 8'h3C}, {1'b0, 4'd3, 8'h01},
    {1'b1, 4'd1, 8'h80}, {1'b0, 4'd0, 8'hFF}, {1'b1, 4'd4, 8'h00}
  };

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int k, base, ib;
    do_reset();
    // R1 reset state
    chk(buf_empty && sclk && txd && !busy && !overrun && !tx_irq, "R1 reset state",
        {buf_empty, sclk, txd, busy, overrun, tx_irq}, 6'b111000);

    // Table walk: R2 data order across modes and divisors
    for (int i = 0; i < 6; i++) begin
      base = rx_count; ib = irq_count;
      dbuf_en = VEC[i][12];
      div_val = 8'(VEC[i][11:8]);
      write_byte(VEC[i][7:0]);
      wait_rx(base + 1);
      chk(rx_bytes[base % 64] == VEC[i][7:0], "R2 LSB-first byte",
          int'(rx_bytes[base % 64]), int'(VEC[i][7:0]));
      chk(irq_count - ib == 1, "R4/R6 one irq per byte", irq_count - ib, 1);
      chk(buf_empty && sclk && txd && !busy, "R8 idle after byte",
          {buf_empty, sclk, txd, busy}, 4'b1110);
    end

    // R3/R4 single-mode irq timing, D=3
    dbuf_en = 1'b0; div_val = 8'd3;
    write_byte(8'h5A);
    chk(!buf_empty, "R10 write clears empty", int'(buf_empty), 0);
    wait_irq(k);
    chk(k == 49, "R3 R4 single irq cycle D=3", k, 49);
    repeat (4) @(negedge clk);

    // R3 divisor 0 acts as 1
    div_val = 8'd0;
    write_byte(8'h11);
    wait_irq(k);
    chk(k == 17, "R3 div zero as one", k, 17);
    repeat (4) @(negedge clk);

    // R6 double-mode immediate move
    dbuf_en = 1'b1; div_val = 8'd2;
    write_byte(8'h77);
    wait_irq(k);
    chk(k == 1, "R6 irq after move", k, 1);
    chk(buf_empty && busy, "R6 empty set at move", {buf_empty, busy}, 2'b11);
    wait_rx(rx_count + 1);

    // R8 no extra irq while idle
    ib = irq_count;
    repeat (40) @(negedge clk);
    chk(irq_count == ib && sclk && txd, "R8 idle no irq", irq_count - ib, 0);

    // R7/R9 chained bytes with a write coinciding with the completion move, D=1
    do_reset();
    dbuf_en = 1'b1; div_val = 8'd1;
    base = rx_count; ib = irq_count;
    write_byte(8'hC3);
    repeat (3) @(negedge clk);
    write_byte(8'h96);
    chk(!buf_empty, "R10 empty cleared while busy", int'(buf_empty), 0);
    repeat (12) @(negedge clk);
    write_byte(8'h2D);
    wait_rx(base + 3);
    chk(rx_bytes[base % 64] == 8'hC3 && rx_bytes[(base+1) % 64] == 8'h96 &&
        rx_bytes[(base+2) % 64] == 8'h2D, "R7 chained byte order",
        int'(rx_bytes[(base+2) % 64]), 8'h2D);
    chk(irq_count - ib == 3, "R7 irq per move", irq_count - ib, 3);
    chk(!overrun, "R9 coincident write no overrun", int'(overrun), 0);

    // R9 overwrite of a full buffer
    base = rx_count; ib = irq_count;
    write_byte(8'hAA);
    write_byte(8'hBB);
    write_byte(8'hCC);
    wait_rx(base + 2);
    repeat (40) @(negedge clk);
    chk(rx_count - base == 2 && rx_bytes[(base+1) % 64] == 8'hCC, "R9 overwrite",
        int'(rx_bytes[(base+1) % 64]), 8'hCC);
    chk(overrun, "R9 overrun set", int'(overrun), 1);
    repeat (5) @(negedge clk);
    chk(overrun, "R9 overrun sticky", int'(overrun), 1);

    // R5 single-mode write while busy is dropped
    do_reset();
    dbuf_en = 1'b0; div_val = 8'd1;
    base = rx_count;
    write_byte(8'h42);
    repeat (5) @(negedge clk);
    write_byte(8'h24);
    chk(overrun, "R5 overrun on busy write", int'(overrun), 1);
    wait_rx(base + 1);
    repeat (40) @(negedge clk);
    chk(rx_count - base == 1 && rx_bytes[base % 64] == 8'h42, "R5 dropped write",
        rx_count - base, 1);

    // R11 mode cleared mid-byte
    do_reset();
    dbuf_en = 1'b1; div_val = 8'd2;
    ib = irq_count; base = rx_count;
    write_byte(8'h5F);
    repeat (6) @(negedge clk);
    dbuf_en = 1'b0;
    wait_rx(base + 1);
    chk(irq_count - ib == 1, "R11 no end irq for double byte", irq_count - ib, 1);
    write_byte(8'h0F);
    wait_irq(k);
    chk(k == 33, "R11 single rule on next byte", k, 33);
    repeat (4) @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule